// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general register storage of a 32-bit processor that runs in seven operating modes. Software always names registers r0 to r15. The block turns each name into one physical register, and which physical register it picks depends on the current mode. Some modes therefore get private copies of some registers, and switching mode needs no save or restore of those registers. The block also keeps one saved status word for each exception mode. Instruction decode, the ALU and exception sequencing are outside it. The program counter lives here as r15, and the caller advances it.

The block has two combinational read ports, one write port and a saved-status read/write pair, all indexed by the architectural register number. The mode register sits inside the block and is loaded through its own write strobe. A user-bank override input lets privileged code reach the user copies of r8 to r14.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted and after it, until the first write, the mode is 10011 (supervisor), every register reads 0, every saved status word is 0 and `illegal_mode` is 0.
- R2: The mode changes only on a clock edge with `mode_we` high, and takes the value of `mode_wdata`. The legal encodings are user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other value raises `illegal_mode` and the block uses the user bank for it.
- R3: r0 to r7 and r15 are a single set of registers that every mode shares.
- R4: In FIQ mode, r8 to r14 are private registers. Writing them leaves the registers of every other mode unchanged.
- R5: IRQ, supervisor, abort and undefined modes each have their own r13 and r14. These modes share r8 to r12 with user mode.
- R6: System mode reads and writes exactly the user registers.
- R7: Each of FIQ, IRQ, supervisor, abort and undefined holds one saved status word, and `spsr_rdata` shows the word of the current mode. In user mode, system mode and an illegal mode, `spsr_rdata` is 0 and a write with `spsr_we` changes nothing.
- R8: A write lands at the clock edge. A read of the same register in that cycle returns the old value, and the new value is visible from the next cycle.
- R9: While `user_bank` is high, reads and writes of r8 to r14 use the user registers, whatever the mode.
- R10: A register write or saved-status write in the same cycle as a mode change uses the mode that applied before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Load the mode register |
| mode_wdata | input | 5 | New mode encoding |
| mode_q | output | 5 | Current mode |
| illegal_mode | output | 1 | Current mode is not one of the seven encodings |
| user_bank | input | 1 | Force r8 to r14 accesses onto the user registers |
| ra_idx | input | 4 | Read port A register number |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B register number |
| rb_data | output | 32 | Read port B data |
| w_en | input | 1 | Register write enable |
| w_idx | input | 4 | Write register number |
| w_data | input | 32 | Write data |
| spsr_we | input | 1 | Saved status write enable |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_rdata | output | 32 | Saved status of the current mode |

## Verification
A wrong mapping from register number to physical register stays hidden until the next read of that register in another mode. The bench therefore compares both read ports and the saved-status port against its model in every cycle, so a corrupted bank shows up on the first read that crosses a mode boundary. A bad mode register or a bad illegal-mode flag shows on `mode_q` and `illegal_mode` in the cycle right after the edge that loaded it. A write that lands in the wrong copy shows within one cycle on any read of either copy.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [4:0]    mode_wdata,
  output logic [4:0]    mode_q,
  output logic          illegal_mode,
  input  logic          user_bank,
  input  logic [3:0]    ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          w_en,
  input  logic [3:0]    w_idx,
  input  logic [DW-1:0] w_data,
  input  logic          spsr_we,
  input  logic [DW-1:0] spsr_wdata,
  output logic [DW-1:0] spsr_rdata
);
  localparam int NPHYS = 31;
  localparam int NSAVE = 5;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111;

  logic [NPHYS-1:0][DW-1:0] gpr_q;
  logic [NSAVE-1:0][DW-1:0] spsr_q;
  logic [2:0] bank;
  logic [4:0] wr_phys;

  always_comb begin
    illegal_mode = 1'b0;
    case (mode_q)
      M_FIQ: bank = 3'd1;
      M_IRQ: bank = 3'd2;
      M_SVC: bank = 3'd3;
      M_ABT: bank = 3'd4;
      M_UND: bank = 3'd5;
      M_USR, M_SYS: bank = 3'd0;
      default: begin bank = 3'd0; illegal_mode = 1'b1; end
    endcase
  end

  function automatic logic [4:0] phys_of(input logic [3:0] idx, input logic [2:0] bk, input logic ub);
    logic [2:0] b;
    b = ub ? 3'd0 : bk;
    if (b == 3'd1 && idx >= 4'd8 && idx <= 4'd14)
      return 5'd8 + {1'b0, idx};
    if (b >= 3'd2 && (idx == 4'd13 || idx == 4'd14))
      return 5'd23 + {1'b0, 3'(b - 3'd2), idx[0]};
    return {1'b0, idx};
  endfunction

  assign wr_phys    = phys_of(w_idx, bank, user_bank);
  assign ra_data    = gpr_q[phys_of(ra_idx, bank, user_bank)];
  assign rb_data    = gpr_q[phys_of(rb_idx, bank, user_bank)];
  assign spsr_rdata = (bank == 3'd0) ? '0 : spsr_q[bank - 3'd1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_SVC;
      gpr_q  <= '0;
      spsr_q <= '0;
    end else begin
      if (w_en) gpr_q[wr_phys] <= w_data;
      if (spsr_we && bank != 3'd0) spsr_q[bank - 3'd1] <= spsr_wdata;
      if (mode_we) mode_q <= mode_wdata;
    end
  end

  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_q));
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_q == $past(mode_wdata));
  a_r7_spsr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_USR || mode_q == M_SYS || illegal_mode) |=> $stable(spsr_q));
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    w_en |=> gpr_q[$past(wr_phys)] == $past(w_data));
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !w_en |=> $stable(gpr_q));
  a_r4_fiq_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (w_en && mode_q == M_FIQ && !user_bank && w_idx >= 4'd8 && w_idx <= 4'd14)
      |=> $stable(gpr_q[15:0]) && $stable(gpr_q[30:23]));
endmodule

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic mode_we = 0, user_bank = 0, w_en = 0, spsr_we = 0;
  logic [4:0] mode_wdata = 0;
  logic [3:0] ra_idx = 0, rb_idx = 0, w_idx = 0;
  logic [31:0] w_data = 0, spsr_wdata = 0;
  logic [4:0] mode_q;
  logic illegal_mode;
  logic [31:0] ra_data, rb_data, spsr_rdata;

  banked_regfile dut_i (.clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_q(mode_q), .illegal_mode(illegal_mode), .user_bank(user_bank), .ra_idx(ra_idx),
    .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data), .w_en(w_en), .w_idx(w_idx),
    .w_data(w_data), .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [31:0] m_user [16];
  logic [31:0] m_bank [6][16];
  logic [31:0] m_spsr [6];
  logic [4:0] m_mode;

  function automatic int mbank(input logic [4:0] m);
    case (m)
      5'b10001: return 1; 5'b10010: return 2; 5'b10011: return 3;
      5'b10111: return 4; 5'b11011: return 5; default: return 0;
    endcase
  endfunction

  function automatic bit mlegal(input logic [4:0] m);
    return m inside {5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
  endfunction

  function automatic bit is_private(input int b, input int idx);
    if (b == 1) return idx >= 8 && idx <= 14;
    if (b >= 2) return idx == 13 || idx == 14;
    return 0;
  endfunction

  function automatic logic [31:0] mread(input int idx, input bit ub);
    int b;
    b = ub ? 0 : mbank(m_mode);
    return is_private(b, idx) ? m_bank[b][idx] : m_user[idx];
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("ra_data", ra_data, mread(int'(ra_idx), user_bank));
    chk("rb_data", rb_data, mread(int'(rb_idx), user_bank));
    chk("spsr_rdata", spsr_rdata, mbank(m_mode) == 0 ? 32'h0 : m_spsr[mbank(m_mode)]);
    chk("mode_q", {27'h0, mode_q}, {27'h0, m_mode});
    chk("illegal_mode", {31'h0, illegal_mode}, {31'h0, !mlegal(m_mode)});
  endtask

  task automatic step(input bit we, input int wi, input logic [31:0] wd, input int ra, input int rb,
                      input bit ub, input bit swe, input logic [31:0] sd, input bit mwe, input logic [4:0] mv);
    int b;
    w_en = we; w_idx = 4'(wi); w_data = wd; ra_idx = 4'(ra); rb_idx = 4'(rb);
    user_bank = ub; spsr_we = swe; spsr_wdata = sd; mode_we = mwe; mode_wdata = mv;
    #1 compare();
    @(posedge clk);
    b = ub ? 0 : mbank(m_mode);
    if (we) begin
      if (is_private(b, wi)) m_bank[b][wi] = wd; else m_user[wi] = wd;
    end
    if (swe && mbank(m_mode) != 0) m_spsr[mbank(m_mode)] = sd;
    if (mwe) m_mode = mv;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [4:0] m);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, m);
  endtask

  task automatic read_all(input bit ub);
    for (int i = 0; i < 16; i += 2) step(0, 0, 0, i, i + 1, ub, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [4:0] modes [8];
    modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111, 5'b10100};
    for (int i = 0; i < 16; i++) begin
      m_user[i] = 0;
      for (int b = 0; b < 6; b++) m_bank[b][i] = 0;
    end
    for (int b = 0; b < 6; b++) m_spsr[b] = 0;
    m_mode = 5'b10011;
    @(negedge clk);
    cur_req = "R1";
    #1 compare();
    repeat (2) @(negedge clk);
    rst_n = 1;
    read_all(0);

    cur_req = "R3";
    for (int i = 0; i < 16; i++) step(1, i, 32'h5000_0000 + 32'(i), i, i, 0, 0, 0, 0, 0);
    set_mode(5'b10000);
    read_all(0);

    cur_req = "R4";
    set_mode(5'b10001);
    for (int i = 8; i < 15; i++) step(1, i, 32'hF100_0000 + 32'(i), i, 0, 0, 0, 0, 0, 0);
    read_all(0);
    set_mode(5'b10000);
    read_all(0);

    cur_req = "R5";
    foreach (modes[k]) if (k >= 2 && k <= 5) begin
      set_mode(modes[k]);
      for (int i = 8; i < 15; i++) step(1, i, {8'(k), 24'(i)}, i, 15, 0, 0, 0, 0, 0);
      read_all(0);
    end

    cur_req = "R6";
    set_mode(5'b11111);
    step(1, 13, 32'h5555_0013, 13, 14, 0, 0, 0, 0, 0);
    set_mode(5'b10000);
    read_all(0);

    cur_req = "R7";
    foreach (modes[k]) begin
      set_mode(modes[k]);
      step(0, 0, 0, 0, 0, 0, 1, {8'hA0, 24'(k)}, 0, 0);
      step(0, 0, 0, 1, 2, 0, 0, 0, 0, 0);
    end
    foreach (modes[k]) set_mode(modes[k]);

    cur_req = "R2";
    set_mode(5'b10100);
    step(1, 13, 32'hBAD0_0013, 13, 14, 0, 0, 0, 0, 0);
    set_mode(5'b10000);
    read_all(0);

    cur_req = "R8";
    set_mode(5'b10010);
    step(1, 14, 32'h0DD0_0014, 14, 14, 0, 0, 0, 0, 0);
    step(0, 0, 0, 14, 14, 0, 0, 0, 0, 0);

    cur_req = "R9";
    set_mode(5'b10001);
    step(1, 9, 32'h0BEE_0009, 9, 13, 1, 0, 0, 0, 0);
    read_all(1);
    read_all(0);

    cur_req = "R10";
    step(1, 10, 32'hCAFE_000A, 10, 10, 0, 1, 32'h1234_5678, 1, 5'b10011);
    set_mode(5'b10001);
    read_all(0);

    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      int mi;
      mi = int'($urandom_range(0, 7));
      step(($urandom % 2) == 1, int'($urandom_range(0, 15)), $urandom, int'($urandom_range(0, 15)),
           int'($urandom_range(0, 15)), ($urandom % 5) == 0, ($urandom % 3) == 0, $urandom,
           ($urandom % 4) == 0, modes[mi]);
    end
    finish_run();
  end
endmodule